// File: doc/BRIEF.md
# Packed Integer Media Arithmetic Unit

This block takes two 64-bit operands and applies one lane-wise integer operation to them, chosen by a 3-bit select. The operand splits into eight 8-bit lanes or four 16-bit lanes, depending on the operation. Lane i always occupies bits [W*i+W-1 : W*i].

The available operations are:
- a rounded average of bytes or words;
- a signed word maximum or minimum;
- an unsigned byte maximum or minimum;
- the upper half of an unsigned 16x16 word product.

A valid strobe launches an operation. The result appears in a register one cycle later, together with its own valid flag. The unit is a single-issue, fixed-latency stage of a media pipeline, and it can accept a new operation every cycle.

Top module: `pmedia_alu`

## Requirements
- R1: Select code 0 computes each 8-bit lane result as (a+b+1)>>1 over unsigned lanes. The sum is widened, so 0xFF averaged with 0xFF gives 0xFF.
- R2: Select code 1 computes each 16-bit lane result as (a+b+1)>>1 over unsigned lanes, widened without overflow.
- R3: Select code 2 returns the larger of each 16-bit lane pair, compared as signed two's complement.
- R4: Select code 3 returns the smaller of each 16-bit lane pair, compared as signed two's complement.
- R5: Select code 4 returns the larger of each 8-bit lane pair, compared as unsigned.
- R6: Select code 5 returns the smaller of each 8-bit lane pair, compared as unsigned.
- R7: Select code 6 returns bits 31:16 of the unsigned 32-bit product of each 16-bit lane pair.
- R8: Select code 7 returns an all-zero result.
- R9: The output valid is high in exactly the cycle after a cycle in which the input strobe is sampled high. The result register loads only on a strobe and holds its value otherwise.
- R10: A synchronous reset clears the output valid and the result register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operation strobe |
| opSel | input | 3 | Operation select (codes 0..7) |
| srcA | input | 64 | First operand |
| srcB | input | 64 | Second operand |
| outValid | output | 1 | Result valid, one cycle after the strobe |
| result | output | 64 | Registered result |

## Verification
Every lane computes its result from its own slice of the operands. A wrong lane split, a wrong signedness choice or a dropped carry therefore shows up as a wrong value in specific lanes in the very cycle after the strobe. An exhaustive sweep over all byte pairs, and over word pairs at the sign and carry edges, catches each such fault in a single result. A stale or missed load of the result register shows up as a mismatch on the cycle after a strobe, or as a changed result while the strobe is low.

// File: rtl/pmedia_pkg.sv
package pmedia_pkg;
  localparam int DATA_W = 64;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam int N_BYTE = DATA_W / BYTE_W;
  localparam int N_WORD = DATA_W / WORD_W;

  typedef enum logic [2:0] {
    OP_AVGB = 3'd0,
    OP_AVGW = 3'd1,
    OP_MAXSW = 3'd2,
    OP_MINSW = 3'd3,
    OP_MAXUB = 3'd4,
    OP_MINUB = 3'd5,
    OP_MULHUW = 3'd6,
    OP_ZERO = 3'd7
  } pmOp_e;

  typedef struct packed {
    logic load;
    logic selAvgB;
    logic selAvgW;
    logic selMaxSW;
    logic selMinSW;
    logic selMaxUB;
    logic selMinUB;
    logic selMulHi;
  } pmCtrl_t;
endpackage

// File: rtl/pmedia_ctrl.sv
module pmedia_ctrl
  import pmedia_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic [2:0] opSel,
  output pmCtrl_t    ctrl,
  output logic       outValid
);
  always_comb begin
    ctrl = '0;
    ctrl.load = inValid;
    unique case (pmOp_e'(opSel))
      OP_AVGB:   ctrl.selAvgB  = 1'b1;
      OP_AVGW:   ctrl.selAvgW  = 1'b1;
      OP_MAXSW:  ctrl.selMaxSW = 1'b1;
      OP_MINSW:  ctrl.selMinSW = 1'b1;
      OP_MAXUB:  ctrl.selMaxUB = 1'b1;
      OP_MINUB:  ctrl.selMinUB = 1'b1;
      OP_MULHUW: ctrl.selMulHi = 1'b1;
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

  // R9: valid follows the strobe by exactly one cycle
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);
  // R8: at most one operation path selected
  a_r8_onehot_sel: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctrl.selAvgB, ctrl.selAvgW, ctrl.selMaxSW, ctrl.selMinSW,
              ctrl.selMaxUB, ctrl.selMinUB, ctrl.selMulHi}));
endmodule

// File: rtl/pmedia_dp.sv
module pmedia_dp
  import pmedia_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int BW = BYTE_W,
  parameter int WW = WORD_W
) (
  input  logic          clk,
  input  logic          rst,
  input  pmCtrl_t       ctrl,
  input  logic [DW-1:0] srcA,
  input  logic [DW-1:0] srcB,
  output logic [DW-1:0] result
);
  localparam int NB = DW / BW;
  localparam int NW = DW / WW;

  logic [DW-1:0] avgB, maxUB, minUB;
  logic [DW-1:0] avgW, maxSW, minSW, mulHi;
  logic [DW-1:0] nextRes;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    logic [BW-1:0] a, b;
    logic [BW:0]   sum;
    assign a   = srcA[i*BW +: BW];
    assign b   = srcB[i*BW +: BW];
    assign sum = {1'b0, a} + {1'b0, b} + {{BW{1'b0}}, 1'b1};
    assign avgB[i*BW +: BW]  = sum[BW:1];
    assign maxUB[i*BW +: BW] = (a > b) ? a : b;
    assign minUB[i*BW +: BW] = (a < b) ? a : b;
  end

  for (genvar i = 0; i < NW; i++) begin : g_word
    logic [WW-1:0]   a, b;
    logic [WW:0]     sum;
    logic [2*WW-1:0] prod;
    logic            aGt;
    assign a    = srcA[i*WW +: WW];
    assign b    = srcB[i*WW +: WW];
    assign sum  = {1'b0, a} + {1'b0, b} + {{WW{1'b0}}, 1'b1};
    assign prod = {{WW{1'b0}}, a} * {{WW{1'b0}}, b};
    assign aGt  = $signed(a) > $signed(b);
    assign avgW[i*WW +: WW]  = sum[WW:1];
    assign maxSW[i*WW +: WW] = aGt ? a : b;
    assign minSW[i*WW +: WW] = aGt ? b : a;
    assign mulHi[i*WW +: WW] = prod[2*WW-1:WW];
  end

  always_comb begin
    nextRes = '0;
    if (ctrl.selAvgB)  nextRes = avgB;
    if (ctrl.selAvgW)  nextRes = avgW;
    if (ctrl.selMaxSW) nextRes = maxSW;
    if (ctrl.selMinSW) nextRes = minSW;
    if (ctrl.selMaxUB) nextRes = maxUB;
    if (ctrl.selMinUB) nextRes = minUB;
    if (ctrl.selMulHi) nextRes = mulHi;
  end

  always_ff @(posedge clk) begin
    if (rst)            result <= '0;
    else if (ctrl.load) result <= nextRes;
  end

  // R9: result holds when nothing is loaded
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !ctrl.load |=> $stable(result));
  // R8: code 7 (no path selected) loads zero
  a_r8_zero: assert property (@(posedge clk) disable iff (rst)
    (ctrl.load && !(ctrl.selAvgB | ctrl.selAvgW | ctrl.selMaxSW | ctrl.selMinSW |
      ctrl.selMaxUB | ctrl.selMinUB | ctrl.selMulHi)) |=> (result == '0));
  // R5: unsigned byte max never below either operand in lane 0
  a_r5_max_bound: assert property (@(posedge clk) disable iff (rst)
    (ctrl.load && ctrl.selMaxUB) |=>
      (result[BW-1:0] >= $past(srcA[BW-1:0])) && (result[BW-1:0] >= $past(srcB[BW-1:0])));
  // R1: byte average lies between lane 0 operands (no overflow)
  a_r1_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (ctrl.load && ctrl.selAvgB && srcA[BW-1:0] <= srcB[BW-1:0]) |=>
      (result[BW-1:0] >= $past(srcA[BW-1:0])) && (result[BW-1:0] <= $past(srcB[BW-1:0])));
endmodule

// File: rtl/pmedia_alu.sv
module pmedia_alu
  import pmedia_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic [2:0]  opSel,
  input  logic [63:0] srcA,
  input  logic [63:0] srcB,
  output logic        outValid,
  output logic [63:0] result
);
  pmCtrl_t ctrl;

  pmedia_ctrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .opSel(opSel),
    .ctrl(ctrl), .outValid(outValid)
  );

  pmedia_dp #(.DW(64), .BW(BYTE_W), .WW(WORD_W)) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .srcA(srcA), .srcB(srcB), .result(result)
  );

  // R10: reset clears valid and result
  a_r10_reset: assert property (@(posedge clk)
    rst |=> (!outValid && result == '0));
endmodule

// File: tb/sim_pmedia_alu.sv
module sim_pmedia_alu;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [2:0]  opSel = '0;
  logic [63:0] srcA = '0, srcB = '0;
  logic        outValid;
  logic [63:0] result;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmedia_alu u0 (.clk(clk), .rst(rst), .inValid(inValid), .opSel(opSel),
    .srcA(srcA), .srcB(srcB), .outValid(outValid), .result(result));

  function automatic logic [63:0] model(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r = '0;
    for (int i = 0; i < 8; i++) begin
      int ua = a[i*8 +: 8];
      int ub = b[i*8 +: 8];
      case (op)
        3'd0: r[i*8 +: 8] = 8'((ua + ub + 1) / 2);
        3'd4: r[i*8 +: 8] = 8'((ua > ub) ? ua : ub);
        3'd5: r[i*8 +: 8] = 8'((ua < ub) ? ua : ub);
        default: ;
      endcase
    end
    for (int i = 0; i < 4; i++) begin
      longint ua = longint'(a[i*16 +: 16]);
      longint ub = longint'(b[i*16 +: 16]);
      longint sa = (ua >= 32768) ? ua - 65536 : ua;
      longint sb = (ub >= 32768) ? ub - 65536 : ub;
      case (op)
        3'd1: r[i*16 +: 16] = 16'((ua + ub + 1) / 2);
        3'd2: r[i*16 +: 16] = 16'((sa > sb) ? sa : sb);
        3'd3: r[i*16 +: 16] = 16'((sa < sb) ? sa : sb);
        3'd6: r[i*16 +: 16] = 16'((ua * ub) / 65536);
        default: ;
      endcase
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  string tags[8] = '{"R1", "R2", "R3", "R4", "R5", "R6", "R7", "R8"};

  task automatic run(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    inValid = 1'b1; opSel = op; srcA = a; srcB = b;
    @(negedge clk);
    inValid = 1'b0;
    check("R9 valid", {63'd0, outValid}, 64'd1);
    check(tags[op], result, model(op, a, b));
  endtask

  initial begin
    repeat (CLK_PERIOD * 40000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 valid", {63'd0, outValid}, 64'd0);
    check("R10 result", result, 64'd0);
    rst = 1'b0;
    // R1 R5 R6: exhaustive byte pairs, eight per vector
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y += 8) begin
        logic [63:0] a, b;
        for (int k = 0; k < 8; k++) begin
          a[k*8 +: 8] = 8'(x);
          b[k*8 +: 8] = 8'(y + k);
        end
        run(3'd0, a, b);
        run(3'd4, a, b);
        run(3'd5, a, b);
      end
    end
    // R2 R3 R4 R7 R8: word edges
    begin
      logic [15:0] edgeV[10] = '{16'h0000, 16'h0001, 16'h7FFE, 16'h7FFF, 16'h8000,
                                 16'h8001, 16'hFFFE, 16'hFFFF, 16'h1234, 16'hC0DE};
      for (int x = 0; x < 10; x++)
        for (int y = 0; y < 10; y++)
          for (int op = 1; op < 8; op++)
            if (op == 1 || op == 2 || op == 3 || op == 6 || op == 7)
              run(3'(op), {edgeV[x], edgeV[y], edgeV[(x+3)%10], edgeV[(y+7)%10]},
                          {edgeV[y], edgeV[x], edgeV[(y+5)%10], edgeV[(x+1)%10]});
    end
    // R9: result holds and valid drops without a strobe
    held = result;
    @(negedge clk);
    srcA = 64'hFFFF_FFFF_FFFF_FFFF; srcB = 64'h1; opSel = 3'd1;
    @(negedge clk);
    check("R9 novalid", {63'd0, outValid}, 64'd0);
    check("R9 hold", result, held);
    // R10: reset mid-run clears state
    run(3'd6, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    @(negedge clk); rst = 1'b1; inValid = 1'b1;
    @(negedge clk); rst = 1'b0; inValid = 1'b0;
    check("R10 rvalid", {63'd0, outValid}, 64'd0);
    check("R10 rresult", result, 64'd0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule